// File: doc/BRIEF.md
# HDLC Transmit Byte Queue with Abort Flush

This block holds outgoing packet bytes between a processor write port and a bit-serial HDLC framer on a shared D-channel. The processor writes one byte per cycle, each with a tag that marks the final byte of a packet. The framer pulls bytes one at a time. When the framer needs a byte in the middle of a packet and the queue is empty, the block aborts the packet. It does the same when the channel access logic reports a collision during a packet. After either abort, the block discards the rest of that packet on its own, one entry per clock, up to and including the next entry tagged as final. Software then sends the whole packet again.

Four sticky event flags record these conditions: the low-level warning, underflow, collision and end of transmission. Reading the status clears them. One interrupt line is the OR of the flags that are enabled. The block also supplies the byte pattern the framer sends between frames. It is either all ones, so that other terminals can win the channel, or the flag pattern.

Top module: `hdlc_txq`

## Requirements
- R1: After reset the queue is empty, `rd_valid` and `full` are low, `status` is 0 and `irq` is low.
- R2: Bytes reach `rd_data`/`rd_last` in the order they were written, with their final-byte tag. The queue holds 19 entries.
- R3: `rd_valid` is high when the queue holds a byte and no discard is running. A byte is removed on a clock where `rd_req` and `rd_valid` are both high.
- R4: If `rd_req` is high while the queue is empty and a packet is partly sent, `abort` pulses, status bit 1 (underflow) is set, and the rest of that packet is discarded, including bytes written later.
- R5: If `collision` is high while a packet is partly sent, `abort` pulses, `rd_valid` is held low in that cycle, status bit 2 (collision) is set, and the rest of the packet is discarded. If no packet is in progress, a collision only sets bit 2.
- R6: A discard removes one entry per clock, up to and including the next entry tagged final. `rd_valid` stays low while it runs, and the next packet then appears intact.
- R7: If `frame_done` is high while the queue is empty and no packet or discard is in progress, status bit 3 (end of transmission) is set.
- R8: Status bit 0 (low level) is set on a clock where the occupancy drops from above 4 entries to 4 or fewer.
- R9: Status bits stay set until a clock with `stat_rd` high clears them. An event in that same cycle leaves its bit set.
- R10: `irq` is high exactly when `status & irq_en` is non-zero.
- R11: `idle_byte` is 8'hFF when `cfg_fill_ones` is 1, and 8'h7E otherwise.
- R12: `full` is high when 19 entries are held. A write while full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one byte |
| wr_data | input | 8 | Byte to queue |
| wr_last | input | 1 | Byte is the final one of its packet |
| full | output | 1 | Queue holds 19 entries |
| rd_req | input | 1 | Framer takes the head byte |
| rd_valid | output | 1 | Head byte is available to the framer |
| rd_data | output | 8 | Head byte |
| rd_last | output | 1 | Head byte is the final one of its packet |
| abort | output | 1 | Pulse: current packet aborted |
| collision | input | 1 | Channel access logic reports a collision |
| frame_done | input | 1 | Framer has sent a closing flag |
| cfg_fill_ones | input | 1 | Interframe fill select: 1 = all ones, 0 = flags |
| idle_byte | output | 8 | Interframe fill pattern |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| irq_en | input | 4 | Per-flag interrupt enable |
| status | output | 4 | Sticky flags: bit0 low, bit1 underflow, bit2 collision, bit3 end of transmission |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an abort whose leftover bytes have not been written yet. After an underflow, the discard must wait on an empty queue. It must then swallow bytes that arrive later, while the next packet is already being written behind them. The directed stimulus builds this by reading a packet dry before its final byte is written, then writing the tail and a second packet back to back. It also raises a collision in the same cycle as a framer fetch. A long random phase mixes writes, fetches, collisions, status reads and closing-flag reports. A behavioural queue model is compared against the design on every clock.

// File: rtl/hdlc_txq_pkg.sv
package hdlc_txq_pkg;
  // Status flag positions
  localparam int FLG_LOW = 0;
  localparam int FLG_UFL = 1;
  localparam int FLG_COL = 2;
  localparam int FLG_EOT = 3;
  localparam int NFLG    = 4;
  // Interframe fill patterns
  localparam logic [7:0] FILL_ONES = 8'hFF;
  localparam logic [7:0] FILL_FLAG = 8'h7E;
endpackage

// File: rtl/hdlc_txq_store.sv
module hdlc_txq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 19,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          wlast,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          head_last,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = DW + 1;

  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;
  logic [EW-1:0] rows [DEPTH];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  // Storage rows, each with its own write enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic [EW-1:0] row_q;
    always_ff @(posedge clk) begin
      if (push_ok && (wp_q == AW'(g))) row_q <= {wlast, wdata};
    end
    assign rows[g] = row_q;
  end

  assign {head_last, head_data} = rows[rp_q];

  always_comb begin
    wp_d  = push_ok ? ptr_inc(wp_q) : wp_q;
    rp_d  = pop_ok  ? ptr_inc(rp_q) : rp_q;
    cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  assign count     = cnt_q;
  assign count_nxt = cnt_d;

  // R12: occupancy never exceeds the depth
  p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R12: a write into a full queue without a pop leaves occupancy unchanged
  p_full_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/hdlc_txq_seq.sv
module hdlc_txq_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic collision,
  input  logic empty,
  input  logic head_last,
  output logic pop,
  output logic fr_valid,
  output logic abort,
  output logic ufl_evt,
  output logic in_pkt,
  output logic flushing
);
  logic in_pkt_q, in_pkt_d;
  logic flush_q, flush_d;
  logic col_abort, fr_pop, fl_pop;

  assign col_abort = collision && in_pkt_q;
  assign fr_valid  = !empty && !flush_q && !col_abort;
  assign fr_pop    = rd_req && fr_valid;
  assign fl_pop    = flush_q && !empty;
  assign pop       = fr_pop || fl_pop;
  assign ufl_evt   = rd_req && empty && in_pkt_q && !flush_q;
  assign abort     = ufl_evt || col_abort;

  always_comb begin
    in_pkt_d = in_pkt_q;
    flush_d  = flush_q;
    if (abort) begin
      in_pkt_d = 1'b0;
      flush_d  = 1'b1;
    end else begin
      if (fr_pop) in_pkt_d = !head_last;
      if (fl_pop && head_last) flush_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      in_pkt_q <= in_pkt_d;
      flush_q  <= flush_d;
    end
  end

  assign in_pkt   = in_pkt_q;
  assign flushing = flush_q;

  // R4: an abort leaves the packet closed and the discard running
  p_abort_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (flush_q && !in_pkt_q));
  // R6: a discard ends only after removing an entry tagged final
  p_flush_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_q) |-> $past(pop && head_last));
  // R6: a discard starts only from an abort
  p_flush_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_q) |-> $past(abort));
  // R5: no fetch is granted in the cycle a collision aborts
  p_col_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (collision && in_pkt_q) |-> !(rd_req && fr_valid));
endmodule

// File: rtl/hdlc_txq_irq.sv
module hdlc_txq_irq
  import hdlc_txq_pkg::*;
#(
  parameter int DEPTH    = 19,
  parameter int LOW_MARK = 4,
  parameter int CW       = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   count,
  input  logic [CW-1:0]   count_nxt,
  input  logic            ufl_evt,
  input  logic            col_evt,
  input  logic            frame_done,
  input  logic            empty,
  input  logic            in_pkt,
  input  logic            flushing,
  input  logic            stat_rd,
  input  logic [NFLG-1:0] irq_en,
  output logic [NFLG-1:0] flags,
  output logic            irq
);
  localparam logic [CW-1:0] MARK = CW'(LOW_MARK);

  logic [NFLG-1:0] flags_q, flags_d, set_v;

  always_comb begin
    set_v          = '0;
    set_v[FLG_LOW] = (count > MARK) && (count_nxt <= MARK);
    set_v[FLG_UFL] = ufl_evt;
    set_v[FLG_COL] = col_evt;
    set_v[FLG_EOT] = frame_done && empty && !in_pkt && !flushing;
    flags_d        = (stat_rd ? '0 : flags_q) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
  assign irq   = |(flags_q & irq_en);

  // R9: without a status read no flag drops
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> (($past(flags_q) & ~flags_q) == '0));
  // R9: a status read with no new event empties the flags
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (set_v == '0)) |=> (flags_q == '0));
  // R4: an underflow is always recorded
  p_ufl_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ufl_evt |=> flags_q[FLG_UFL]);
  // R5: a collision is always recorded
  p_col_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    col_evt |=> flags_q[FLG_COL]);
endmodule

// File: rtl/hdlc_txq.sv
module hdlc_txq
  import hdlc_txq_pkg::*;
#(
  parameter int DW       = 8,
  parameter int DEPTH    = 19,
  parameter int LOW_MARK = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            wr_last,
  output logic            full,
  input  logic            rd_req,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic            rd_last,
  output logic            abort,
  input  logic            collision,
  input  logic            frame_done,
  input  logic            cfg_fill_ones,
  output logic [DW-1:0]   idle_byte,
  input  logic            stat_rd,
  input  logic [NFLG-1:0] irq_en,
  output logic [NFLG-1:0] status,
  output logic            irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]    rs_q;
  logic          rst_i_n;
  logic          pop, empty, head_last, ufl_evt, in_pkt, flushing;
  logic [CW-1:0] count, count_nxt;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  hdlc_txq_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_i_n),
    .push(wr_en), .wdata(wr_data), .wlast(wr_last),
    .pop(pop), .head_data(rd_data), .head_last(head_last),
    .count(count), .count_nxt(count_nxt), .empty(empty), .full(full)
  );

  hdlc_txq_seq u_seq (
    .clk(clk), .rst_n(rst_i_n),
    .rd_req(rd_req), .collision(collision), .empty(empty), .head_last(head_last),
    .pop(pop), .fr_valid(rd_valid), .abort(abort), .ufl_evt(ufl_evt),
    .in_pkt(in_pkt), .flushing(flushing)
  );

  hdlc_txq_irq #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .CW(CW)) u_irq (
    .clk(clk), .rst_n(rst_i_n),
    .count(count), .count_nxt(count_nxt),
    .ufl_evt(ufl_evt), .col_evt(collision), .frame_done(frame_done),
    .empty(empty), .in_pkt(in_pkt), .flushing(flushing),
    .stat_rd(stat_rd), .irq_en(irq_en), .flags(status), .irq(irq)
  );

  assign rd_last   = head_last;
  assign idle_byte = cfg_fill_ones ? DW'(FILL_ONES) : DW'(FILL_FLAG);

  // R1: the queue is idle right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_i_n |=> (!rd_valid && !full && status == '0));
endmodule

// File: tb/test_hdlc_txq.sv
module test_hdlc_txq;
  localparam int DEPTH = 19;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_last, rd_req, collision, frame_done, cfg_fill_ones, stat_rd;
  logic [7:0] wr_data;
  logic [3:0] irq_en;
  logic       full, rd_valid, rd_last, abort, irq;
  logic [7:0] rd_data, idle_byte;
  logic [3:0] status;

  always #10 clk = ~clk; // 50 MHz

  hdlc_txq i_hdlc_txq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
    .full(full), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last), .abort(abort), .collision(collision), .frame_done(frame_done),
    .cfg_fill_ones(cfg_fill_ones), .idle_byte(idle_byte), .stat_rd(stat_rd),
    .irq_en(irq_en), .status(status), .irq(irq)
  );

  // Reference model
  logic [8:0] mq[$];
  bit         m_inpkt, m_flush;
  bit [3:0]   m_flags;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic quiet();
    wr_en = 0; wr_data = 0; wr_last = 0; rd_req = 0;
    collision = 0; frame_done = 0; stat_rd = 0;
  endtask

  // One clock: compare mid-cycle, then advance the model at the edge
  task automatic step(input bit model_on = 1);
    bit col_ab, ev, ufl, popped_last, fr_pop, fl_pop;
    int old_n, new_n;
    bit [3:0] ev_f;
    #5;
    col_ab = collision && m_inpkt;
    ev     = (mq.size() > 0) && !m_flush && !col_ab;
    ufl    = rd_req && (mq.size() == 0) && m_inpkt && !m_flush;
    chk("R3 rd_valid", rd_valid, ev);
    if (ev) chk("R2 head entry", {rd_last, rd_data}, mq[0]);
    chk("R12 full", full, mq.size() == DEPTH);
    chk("R9 status", status, m_flags);
    chk("R10 irq", irq, |(m_flags & irq_en));
    chk("R5 abort", abort, model_on && (ufl || col_ab));
    chk("R11 idle_byte", idle_byte, cfg_fill_ones ? 8'hFF : 8'h7E);
    @(posedge clk);
    if (model_on) begin
      old_n  = mq.size();
      fl_pop = m_flush && old_n > 0;
      fr_pop = rd_req && ev;
      ev_f   = 0;
      ev_f[3] = frame_done && old_n == 0 && !m_inpkt && !m_flush;
      ev_f[2] = collision;
      ev_f[1] = ufl;
      if (fl_pop || fr_pop) begin
        popped_last = mq[0][8];
        void'(mq.pop_front());
        if (fl_pop && popped_last) m_flush = 0;
        if (fr_pop) m_inpkt = !popped_last;
      end
      if (wr_en && old_n < DEPTH) mq.push_back({wr_last, wr_data});
      if (ufl || col_ab) begin
        m_flush = 1; m_inpkt = 0;
      end
      new_n   = mq.size();
      ev_f[0] = old_n > 4 && new_n <= 4;
      m_flags = (stat_rd ? 4'h0 : m_flags) | ev_f;
    end
    #1;
  endtask

  task automatic wr(input logic [7:0] d, input bit last);
    quiet(); wr_en = 1; wr_data = d; wr_last = last; step();
  endtask

  task automatic rd();
    quiet(); rd_req = 1; step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin quiet(); step(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog act=timeout exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    quiet(); cfg_fill_ones = 1; irq_en = 4'hF; rst_n = 0;
    m_inpkt = 0; m_flush = 0; m_flags = 0;
    for (int i = 0; i < 3; i++) step(0);
    rst_n = 1;
    idle(3);
    // R1: reset state
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 full", full, 0);
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);

    // R2 R3: short packet in and out, then end of transmission (R7)
    wr(8'h11, 0); wr(8'h22, 0); wr(8'h33, 1);
    rd(); rd(); rd();
    quiet(); frame_done = 1; step();
    chk("R7 eot flag", status[3], 1);
    quiet(); stat_rd = 1; step();
    chk("R9 cleared", status, 0);

    // R12: fill past the depth; R8: low-level on drain
    for (int i = 0; i < DEPTH + 1; i++) wr(8'(8'h40 + i), i == DEPTH - 1);
    chk("R12 full high", full, 1);
    for (int i = 0; i < DEPTH - 4; i++) rd();
    chk("R8 low flag", status[0], 1);
    for (int i = 0; i < 4; i++) rd();
    chk("R12 drained", rd_valid, 0);
    quiet(); stat_rd = 1; step();

    // R4 R6: underflow with the tail written afterwards
    wr(8'h51, 0); wr(8'h52, 0);
    rd(); rd(); rd();
    chk("R4 underflow flag", status[1], 1);
    wr(8'h53, 0); wr(8'h54, 0); wr(8'h55, 1);
    wr(8'hA1, 0); wr(8'hA2, 1);
    idle(2);
    chk("R6 next packet intact", {rd_valid, rd_data}, {1'b1, 8'hA1});
    rd(); rd();
    quiet(); stat_rd = 1; step();

    // R5 R6: collision in the same cycle as a fetch
    wr(8'h61, 0); wr(8'h62, 0); wr(8'h63, 0); wr(8'h64, 1); wr(8'hB1, 1);
    rd();
    quiet(); collision = 1; rd_req = 1; step();
    chk("R5 collision flag", status[2], 1);
    idle(3);
    chk("R6 after discard", {rd_valid, rd_data, rd_last}, {1'b1, 8'hB1, 1'b1});
    rd();
    quiet(); stat_rd = 1; step();

    // R5: collision with no packet in progress leaves the queue alone
    wr(8'hC1, 1);
    quiet(); collision = 1; step();
    chk("R5 idle collision keeps byte", {rd_valid, rd_data}, {1'b1, 8'hC1});
    rd();

    // R9: read and event in the same cycle keep the new bit
    quiet(); stat_rd = 1; collision = 1; step();
    chk("R9 set wins", status, 4'b0100);

    // R10: enables gate the interrupt
    irq_en = 4'b1011; idle(1);
    chk("R10 masked", irq, 0);
    irq_en = 4'b0100; idle(1);
    chk("R10 enabled", irq, 1);

    // R11: fill pattern select
    cfg_fill_ones = 0; idle(1);
    chk("R11 flag fill", idle_byte, 8'h7E);
    cfg_fill_ones = 1; idle(1);
    quiet(); stat_rd = 1; step();

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      quiet();
      wr_en      = ($urandom % 3) != 0;
      wr_data    = 8'($urandom);
      wr_last    = ($urandom % 4) == 0;
      rd_req     = ($urandom % 2) == 0;
      collision  = ($urandom % 40) == 0;
      frame_done = ($urandom % 10) == 0;
      stat_rd    = ($urandom % 8) == 0;
      if (($urandom % 50) == 0) irq_en = 4'($urandom);
      if (($urandom % 60) == 0) cfg_fill_ones = ~cfg_fill_ones;
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule